// File: doc/BRIEF.md
# High/Low Count Clock Divider

This block derives a slower clock from an input clock. The divide ratio can be changed at run time to any integer from 1 to 128. Internally the ratio is not held as one terminal count. A small encoder splits the requested ratio into four fields: a high-phase length, a low-phase length, an odd-ratio flag and a pass-through flag. A phase counter then walks through the high phase and the low phase.

For odd ratios, a register clocked on the falling input edge stretches the high phase by half an input period. This keeps the output duty cycle as close to even as the ratio allows. A ratio of 1 skips the counters, and the input clock is routed straight to the output.

A new ratio is taken only at the boundary between two output periods, so changing the request never produces a shortened pulse. Each 6-bit count field uses the value 0 to stand for 64, which lets a ratio of 128 fit in the fields.

Top module: `hl_clock_divider`

## Requirements
- R1: While `rst_n` is low, and from its release until the first rising edge of `clk_in` after that release, `clk_out` is low whatever `div_req` holds.
- R2: A request of 0 acts as a ratio of 1, and any request above 128 acts as a ratio of 128.
- R3: For an effective ratio d from 2 to 128, one `clk_out` period spans exactly d periods of `clk_in`, and every period starts with a rising edge of `clk_out` aligned to a rising edge of `clk_in`.
- R4: For an even ratio d, `clk_out` is high for d/2 input periods and low for d/2 input periods.
- R5: For an odd ratio d of 3 or more, the high phase lasts floor(d/2) input periods plus one half period, and the falling edge of `clk_out` lines up with a falling edge of `clk_in`. In half-period units, `clk_out` is high for the first d of the 2·d half periods of every ratio.
- R6: With a ratio of 1, `clk_out` follows `clk_in`.
- R7: `div_req` is sampled only on the rising input edge that ends an output period. A change made inside a period has no effect until that period completes. The first output period after reset begins with its high phase at the first rising input edge.
- R8: The high and low counts are 6-bit fields, with the value 0 standing for 64. Ratios 127 and 128 therefore produce 127- and 128-cycle periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_req | input | 8 | Requested divide ratio, clamped to 1..128 |
| clk_out | output | 1 | Divided clock |

## Verification
The bench builds the block with its default 6-bit count fields and an 8-bit request. This brings every ratio from 1 to 128, together with the clamped codes 0 and above 128, within reach of one sweep. A half-period reference model checks the output after every input edge. It catches the wrap of a zero count field to 64 at ratios 127 and 128, the stretched falling edge of every odd ratio, and the bypass path. A final stretch changes the request every few cycles, so that changes land at every point inside a period. This shows that each new ratio waits for the current period to finish.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Width of each phase count field; 0 in a field stands for 2**CNT_W.
  localparam int CNT_W     = 6;
  localparam int LEN_W     = CNT_W + 1;
  localparam int DIV_VAL_W = CNT_W + 2;
  localparam int MAX_LEN   = 1 << CNT_W;
  localparam int MAX_DIV   = 2 * MAX_LEN;

  typedef struct packed {
    logic [CNT_W-1:0] hi_cnt;
    logic [CNT_W-1:0] lo_cnt;
    logic             odd_edge;
    logic             bypass;
  } div_cfg_t;

  // Length in input cycles that a count field stands for.
  function automatic logic [LEN_W-1:0] field_len(input logic [CNT_W-1:0] f);
    if (f == '0) return LEN_W'(MAX_LEN);
    return {1'b0, f};
  endfunction

  // Split a clamped ratio into high/low counts and the two flag bits.
  function automatic div_cfg_t encode_div(input logic [DIV_VAL_W-1:0] d);
    div_cfg_t             c;
    logic [DIV_VAL_W-1:0] h;
    logic [DIV_VAL_W-1:0] l;
    h          = d >> 1;
    l          = d - h;
    c.hi_cnt   = h[CNT_W-1:0];
    c.lo_cnt   = l[CNT_W-1:0];
    c.odd_edge = d[0];
    c.bypass   = (d == DIV_VAL_W'(1));
    return c;
  endfunction

endpackage

// File: rtl/clkdiv_encoder.sv
module clkdiv_encoder
  import clkdiv_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic [DIV_W-1:0] div_req,
  output div_cfg_t         cfg
);

  logic [DIV_VAL_W-1:0] d_clamped;

  always_comb begin
    if (div_req == '0)
      d_clamped = DIV_VAL_W'(1);
    else if (int'(div_req) > MAX_DIV)
      d_clamped = DIV_VAL_W'(MAX_DIV);
    else
      d_clamped = DIV_VAL_W'(div_req);
    cfg = encode_div(d_clamped);
  end

  always_comb begin
    if (!cfg.bypass) begin
      AST_FIELD_SUM: assert ({1'b0, field_len(cfg.hi_cnt)} + {1'b0, field_len(cfg.lo_cnt)} == d_clamped); // R3
    end
  end

endmodule

// File: rtl/clkdiv_phase_counter.sv
module clkdiv_phase_counter
  import clkdiv_pkg::*;
(
  input  logic     clk_in,
  input  logic     rst_n,
  input  div_cfg_t cfg_next,
  output div_cfg_t cfg_q,
  output logic     pos_level
);

  logic [LEN_W-1:0] cnt;
  logic             period_end;
  logic             high_end;

  // Period boundary: low phase on its last cycle, or idle after reset/bypass.
  assign period_end = !pos_level && (cnt <= LEN_W'(1));
  assign high_end   = pos_level && (cnt == LEN_W'(1));

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      pos_level <= 1'b0;
      cnt       <= '0;
      cfg_q     <= '0;
    end else if (period_end) begin
      cfg_q <= cfg_next;
      if (cfg_next.bypass) begin
        pos_level <= 1'b0;
        cnt       <= '0;
      end else begin
        pos_level <= 1'b1;
        cnt       <= field_len(cfg_next.hi_cnt);
      end
    end else if (high_end) begin
      pos_level <= 1'b0;
      cnt       <= field_len(cfg_q.lo_cnt);
    end else begin
      cnt <= cnt - LEN_W'(1);
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk_in) disable iff (!rst_n)
    !period_end |=> $stable(cfg_q)); // R7

  AST_HIGH_START: assert property (@(posedge clk_in) disable iff (!rst_n)
    (period_end && !cfg_next.bypass) |=> pos_level); // R7

  AST_CNT_BOUND: assert property (@(posedge clk_in) disable iff (!rst_n)
    cnt <= LEN_W'(MAX_LEN)); // R8

  AST_BYPASS_IDLE: assert property (@(posedge clk_in) disable iff (!rst_n)
    cfg_q.bypass |-> !pos_level); // R6

endmodule

// File: rtl/clkdiv_half_edge.sv
module clkdiv_half_edge (
  input  logic clk_in,
  input  logic rst_n,
  input  logic pos_level,
  input  logic odd_edge,
  output logic div_level
);

  logic neg_q;

  // Copy of the rising-edge level, half an input period late.
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= pos_level;
  end

  assign div_level = pos_level | (odd_edge & neg_q);

  AST_NEG_TRACKS: assert property (@(posedge clk_in) disable iff (!rst_n)
    neg_q == pos_level); // R5

endmodule

// File: rtl/hl_clock_divider.sv
module hl_clock_divider
  import clkdiv_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_req,
  output logic             clk_out
);

  div_cfg_t cfg_next;
  div_cfg_t cfg_q;
  logic     pos_level;
  logic     div_level;

  clkdiv_encoder #(.DIV_W(DIV_W)) u_encoder (
    .div_req (div_req),
    .cfg     (cfg_next)
  );

  clkdiv_phase_counter u_counter (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .cfg_next  (cfg_next),
    .cfg_q     (cfg_q),
    .pos_level (pos_level)
  );

  clkdiv_half_edge u_half (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .pos_level (pos_level),
    .odd_edge  (cfg_q.odd_edge),
    .div_level (div_level)
  );

  // Switch-over happens at a rising input edge, where both sources agree.
  assign clk_out = cfg_q.bypass ? clk_in : div_level;

  always_comb begin
    if (!rst_n) begin
      AST_RESET_LOW: assert (!clk_out); // R1
    end
  end

endmodule

// File: tb/test_hl_clock_divider.sv
module test_hl_clock_divider;

  logic       clk_in = 1'b0;
  logic       rst_n  = 1'b0;
  logic [7:0] div_req = 8'd5;
  logic       clk_out;
  logic [7:0] req_at_edge = 8'd0;

  int    vectors   = 0;
  int    errors    = 0;
  bit    mon_en    = 1'b0;
  bit    done      = 1'b0;
  string phase_tag = "";

  hl_clock_divider i_hl_clock_divider (
    .clk_in  (clk_in),
    .rst_n   (rst_n),
    .div_req (div_req),
    .clk_out (clk_out)
  );

  always #2 clk_in = ~clk_in;

  // Copy of the request as seen on each rising edge.
  always @(posedge clk_in) req_at_edge <= div_req;

  function automatic int clamp_ratio(input int raw);
    if (raw == 0)  return 1;
    if (raw > 128) return 128;
    return raw;
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: clk_out=%0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string tag_for(input int raw, input int d);
    if (phase_tag != "")     return phase_tag;
    if (raw == 0 || raw > 128) return "R2";
    if (d == 1)              return "R6";
    if (d >= 127)            return "R8";
    if (d % 2 == 1)          return "R5";
    return "R4";
  endfunction

  // Reference model, one step per half period: high for the first d of the
  // 2*d half periods in each period; the ratio is taken at each period start (R3, R7).
  initial begin
    int k = 0;
    int cur_d = 0;
    int raw = 0;
    wait (mon_en);
    forever begin
      @(posedge clk_in); #1;
      if (k >= cur_d) begin
        k     = 0;
        raw   = int'(req_at_edge);
        cur_d = clamp_ratio(raw);
      end
      if (mon_en) chk(clk_out, (2 * k) < cur_d, tag_for(raw, cur_d),
                      $sformatf("d=%0d half=%0d", cur_d, 2 * k));
      @(negedge clk_in); #1;
      if (mon_en) chk(clk_out, (2 * k + 1) < cur_d, tag_for(raw, cur_d),
                      $sformatf("d=%0d half=%0d", cur_d, 2 * k + 1));
      k++;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    int seed = 17;
    // R1: low in reset, for a divided and a bypass request
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_in); #1; chk(clk_out, 1'b0, "R1", "in reset, high input phase");
      @(negedge clk_in); #1; chk(clk_out, 1'b0, "R1", "in reset, low input phase");
      div_req = (i < 2) ? 8'd5 : 8'd1;
    end
    div_req = 8'd4;
    @(negedge clk_in); #1;
    rst_n = 1'b1;
    chk(clk_out, 1'b0, "R1", "released, before first rising edge");
    mon_en = 1'b1;

    // Sweep all request codes 0..140 plus two far out-of-range codes.
    for (int raw = 0; raw <= 142; raw++) begin
      int code = (raw == 141) ? 200 : (raw == 142) ? 255 : raw;
      @(negedge clk_in); #1;
      div_req = 8'(code);
      repeat (2 * clamp_ratio(code) + 3) @(posedge clk_in);
    end

    // R7: requests changed every few cycles, at all points of a period.
    @(negedge clk_in); #1;
    phase_tag = "R7";
    for (int i = 0; i < 200; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      @(negedge clk_in); #1;
      div_req = 8'((seed >> 8) % 12);
      repeat (1 + (seed >> 4) % 7) @(posedge clk_in);
    end
    @(negedge clk_in); #1;
    mon_en = 1'b0;
    finish_run();
  end

endmodule